// File: doc/BRIEF.md
# Power-Up Strap Latch and Test-Mode Selector

This block captures the board-level configuration straps of a clock generator at the moment the power-good signal is first seen high. Until then its capture registers are transparent and simply track the pins on every clock. After capture they hold, so later activity on the shared pins cannot disturb the configuration. The captured values give the frequency-select code and the enables that choose each multiplexed pin's function.

The block also owns the test-mode state. Test mode can be requested in two ways: by a strap on the three-level select pin, which counts when that pin is above its high threshold at capture, or later by a register entry bit. Test mode is sticky, and only a reset (a power cycle) clears it. While it is active, a 2-bit output mode tells the output stage to drive normally, to float its outputs, or to drive the reference-divide clock. The real-time test pin or a register bit picks between the last two, depending on how test mode was entered.

Top module: `pwrup_strap_ctl`

## Requirements
- R1: With reset low at a clock edge, the block is unlocked, test mode is inactive, the output mode is 00 (normal) and every captured value is 0.
- R2: While not locked, each clock edge copies the strap pins into the captured outputs. The first edge that sees power-good high captures once more and locks. After that, the captured outputs hold no matter what the pins or power-good do.
- R3: The stop-function strap selects the pin function. A captured 0 gives stop_in_en_o=1 and extra_pair_en_o=0; a captured 1 gives the reverse.
- R4: The debug strap selects the pair function. A captured 1 gives dbg_pair_en_o=1 and gp_pair_en_o=0; a captured 0 gives the reverse.
- R5: freq_code_o is {msb, fsel_b_i, fsel_a_i}. The msb is fsel_lo_i when fsel_hi_i is 0, and 0 when fsel_hi_i is 1. freq_rsvd_o is 1 exactly when the code is 111. Codes 000..110 map to 266.66, 133.33, 200, 166.66, 333.33, 100 and 400 MHz.
- R6: If fsel_hi_i was 1 at the locking edge, test mode is active. While only this source is active, the output mode follows tm_pin_i one edge later: 0 gives 01 (Hi-Z) and 1 gives 10 (reference-divide).
- R7: An edge that is already locked and sees power-good and reg_test_entry_i high enters test mode. From that edge on, reg_test_sel_i picks Hi-Z (0) or reference-divide (1), and tm_pin_i has no effect.
- R8: When both the strap and the register bit have requested test mode, reg_test_sel_i alone decides the output mode.
- R9: Once active, test mode stays active until reset, even if the entry bit is cleared or power-good drops.
- R10: Output mode encodings are 00 normal, 01 Hi-Z and 10 reference-divide. At any edge that sees power-good low, or that happens before lock, the mode register loads 00.
- R11: An entry request seen before lock, or at an edge with power-good low, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power cycle) |
| pwr_good_i | input | 1 | Power-good indication |
| strap_stop_i | input | 1 | Stop-function strap pin |
| strap_dbg_i | input | 1 | Debug-pair strap pin |
| fsel_hi_i | input | 1 | Three-level pin above high threshold |
| fsel_lo_i | input | 1 | Three-level pin above low threshold |
| fsel_b_i | input | 1 | Frequency-select middle bit pin |
| fsel_a_i | input | 1 | Frequency-select least significant pin |
| tm_pin_i | input | 1 | Real-time test output-select pin |
| reg_test_entry_i | input | 1 | Register bit requesting test mode |
| reg_test_sel_i | input | 1 | Register bit selecting test output |
| locked_o | output | 1 | Straps captured |
| freq_code_o | output | 3 | Captured frequency code |
| freq_rsvd_o | output | 1 | Captured code is reserved |
| stop_in_en_o | output | 1 | Stop-input pin function enabled |
| extra_pair_en_o | output | 1 | Extra stoppable clock pair enabled |
| dbg_pair_en_o | output | 1 | Shared pair drives debug clock |
| gp_pair_en_o | output | 1 | Shared pair drives general clock |
| test_active_o | output | 1 | Test mode entered |
| out_mode_o | output | 2 | Output mode: 00 normal, 01 Hi-Z, 10 ref-divide |

## Verification
Every output is due one edge after the inputs that cause it. Captured straps and lock follow the pins at the same edge that samples them, and the output mode and test flag reflect the power-good, test-pin and register inputs present at that edge. The bench drives inputs at the falling edge, advances a behavioural model at each rising edge from the same input values, and compares every output at the next falling edge. Each mismatch is therefore tied to the exact edge that produced it.

// File: rtl/strap_pkg.sv
// Shared types for the power-up strap latch and test-mode selector.
// Assumes the output stage decodes the 2-bit mode exactly as listed here.
package strap_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_HIZ    = 2'b01,
        MODE_REFDIV = 2'b10
    } out_mode_e;
endpackage

// File: rtl/strap_capture.sv
// Transparent-until-lock capture of the configuration straps.
// Tracks the pins every edge until power-good is first seen high, captures at
// that edge and holds until reset. Assumes the pins are already synchronised.
module strap_capture #(
    parameter int FS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pg_i,
    input  logic            fs_hi_i,
    input  logic            fs_lo_i,
    input  logic [FS_W-2:0] fs_low_bits_i,
    input  logic            strap_stop_i,
    input  logic            strap_dbg_i,
    output logic            locked_o,
    output logic            hw_test_o,
    output logic [FS_W-1:0] fs_code_o,
    output logic            stop_q_o,
    output logic            dbg_q_o
);
    logic            locked_q;
    logic            hw_test_q;
    logic [FS_W-1:0] fs_code_q;
    logic            stop_q;
    logic            dbg_q;
    logic            fs_msb;

    // Three-level pin: above high threshold means test request, msb forced 0.
    always_comb fs_msb = fs_hi_i ? 1'b0 : fs_lo_i;

    // Follow the pins while open; close on the first edge with power-good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q  <= 1'b0;
            hw_test_q <= 1'b0;
            fs_code_q <= '0;
            stop_q    <= 1'b0;
            dbg_q     <= 1'b0;
        end else if (!locked_q) begin
            locked_q  <= pg_i;
            hw_test_q <= fs_hi_i;
            fs_code_q <= {fs_msb, fs_low_bits_i};
            stop_q    <= strap_stop_i;
            dbg_q     <= strap_dbg_i;
        end
    end

    assign locked_o  = locked_q;
    assign hw_test_o = hw_test_q;
    assign fs_code_o = fs_code_q;
    assign stop_q_o  = stop_q;
    assign dbg_q_o   = dbg_q;

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> ($stable(fs_code_q) && $stable(stop_q) && $stable(dbg_q) && $stable(hw_test_q))); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q); // R2
    AST_LOCK_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q && !pg_i) |=> !locked_q); // R2
endmodule

// File: rtl/test_mode_ctl.sv
// One-shot test-mode entry and output-mode decode.
// Assumes locked_i and hw_test_i come from the strap capture and stay frozen
// after lock; only reset clears the register-entered test state.
module test_mode_ctl
    import strap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pg_i,
    input  logic      locked_i,
    input  logic      hw_test_i,
    input  logic      tm_pin_i,
    input  logic      entry_i,
    input  logic      sel_i,
    output logic      test_active_o,
    output out_mode_e mode_o
);
    logic      sw_test_q;
    logic      sw_test_d;
    out_mode_e mode_d;
    out_mode_e mode_q;

    // Register entry counts only when locked and powered; it never clears.
    always_comb sw_test_d = sw_test_q | (locked_i & pg_i & entry_i);

    // Register source wins over the strap source; either forces test output.
    always_comb begin
        if (!pg_i || !locked_i)
            mode_d = MODE_NORMAL;
        else if (sw_test_d)
            mode_d = sel_i ? MODE_REFDIV : MODE_HIZ;
        else if (hw_test_i)
            mode_d = tm_pin_i ? MODE_REFDIV : MODE_HIZ;
        else
            mode_d = MODE_NORMAL;
    end

    // Hold the sticky entry flag and the registered output mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_test_q <= 1'b0;
            mode_q    <= MODE_NORMAL;
        end else begin
            sw_test_q <= sw_test_d;
            mode_q    <= mode_d;
        end
    end

    assign test_active_o = locked_i & (hw_test_i | sw_test_q);
    assign mode_o        = mode_q;

    AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        test_active_o |=> test_active_o); // R9
    AST_NORMAL_PG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_i |=> (mode_q == MODE_NORMAL)); // R10
    AST_MODE_IMPLIES_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_NORMAL) |-> test_active_o); // R6
    AST_SW_SEL_RULES: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_test_q && pg_i) |=> (mode_q == ($past(sel_i) ? MODE_REFDIV : MODE_HIZ))); // R8
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'b11); // R10
endmodule

// File: rtl/pwrup_strap_ctl.sv
// Top of the power-up strap latch and test-mode selector.
// Captures straps at first power-good, derives pin-function enables and the
// frequency code, and drives the test output mode. Synchronous active-low reset.
module pwrup_strap_ctl
    import strap_pkg::*;
#(
    parameter int FS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_good_i,
    input  logic            strap_stop_i,
    input  logic            strap_dbg_i,
    input  logic            fsel_hi_i,
    input  logic            fsel_lo_i,
    input  logic            fsel_b_i,
    input  logic            fsel_a_i,
    input  logic            tm_pin_i,
    input  logic            reg_test_entry_i,
    input  logic            reg_test_sel_i,
    output logic            locked_o,
    output logic [FS_W-1:0] freq_code_o,
    output logic            freq_rsvd_o,
    output logic            stop_in_en_o,
    output logic            extra_pair_en_o,
    output logic            dbg_pair_en_o,
    output logic            gp_pair_en_o,
    output logic            test_active_o,
    output logic [1:0]      out_mode_o
);
    localparam logic [FS_W-1:0] RSVD_CODE = {FS_W{1'b1}};

    logic            locked;
    logic            hw_test;
    logic [FS_W-1:0] fs_code;
    logic            stop_q;
    logic            dbg_q;
    out_mode_e       mode;

    strap_capture #(.FS_W(FS_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .pg_i         (pwr_good_i),
        .fs_hi_i      (fsel_hi_i),
        .fs_lo_i      (fsel_lo_i),
        .fs_low_bits_i({fsel_b_i, fsel_a_i}),
        .strap_stop_i (strap_stop_i),
        .strap_dbg_i  (strap_dbg_i),
        .locked_o     (locked),
        .hw_test_o    (hw_test),
        .fs_code_o    (fs_code),
        .stop_q_o     (stop_q),
        .dbg_q_o      (dbg_q)
    );

    test_mode_ctl u_tm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pg_i         (pwr_good_i),
        .locked_i     (locked),
        .hw_test_i    (hw_test),
        .tm_pin_i     (tm_pin_i),
        .entry_i      (reg_test_entry_i),
        .sel_i        (reg_test_sel_i),
        .test_active_o(test_active_o),
        .mode_o       (mode)
    );

    // Pin-function enables are complementary decodes of the captured straps.
    always_comb begin
        stop_in_en_o    = ~stop_q;
        extra_pair_en_o = stop_q;
        dbg_pair_en_o   = dbg_q;
        gp_pair_en_o    = ~dbg_q;
        freq_rsvd_o     = (fs_code == RSVD_CODE);
    end

    assign locked_o    = locked;
    assign freq_code_o = fs_code;
    assign out_mode_o  = mode;

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({dbg_pair_en_o, gp_pair_en_o}) && $onehot({stop_in_en_o, extra_pair_en_o})); // R3 R4
endmodule

// File: tb/pwrup_strap_ctl_test.sv
module pwrup_strap_ctl_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, pg = 1'b0, s_stop = 1'b0, s_dbg = 1'b0;
    logic f_hi = 1'b0, f_lo = 1'b0, f_b = 1'b0, f_a = 1'b0;
    logic tm = 1'b0, entry = 1'b0, sel = 1'b0;
    logic locked, rsvd, stop_en, extra_en, dbg_en, gp_en, tact;
    logic [2:0] code;
    logic [1:0] mode;

    int checks = 0, fails = 0;

    // behavioural model state
    int m_locked = 0, m_hw = 0, m_sw = 0, m_mode = 0, m_code = 0, m_stop = 0, m_dbg = 0;

    pwrup_strap_ctl uut (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .strap_stop_i(s_stop),
        .strap_dbg_i(s_dbg), .fsel_hi_i(f_hi), .fsel_lo_i(f_lo), .fsel_b_i(f_b),
        .fsel_a_i(f_a), .tm_pin_i(tm), .reg_test_entry_i(entry),
        .reg_test_sel_i(sel), .locked_o(locked), .freq_code_o(code),
        .freq_rsvd_o(rsvd), .stop_in_en_o(stop_en), .extra_pair_en_o(extra_en),
        .dbg_pair_en_o(dbg_en), .gp_pair_en_o(gp_en), .test_active_o(tact),
        .out_mode_o(mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model from the inputs seen at this rising edge.
    task automatic model_edge();
        int sw_n;
        if (!rst_n) begin
            m_locked = 0; m_hw = 0; m_sw = 0; m_mode = 0;
            m_code = 0; m_stop = 0; m_dbg = 0;
        end else begin
            sw_n = (m_sw != 0 || (m_locked != 0 && pg && entry)) ? 1 : 0;
            if (!pg || m_locked == 0) m_mode = 0;
            else if (sw_n != 0)       m_mode = sel ? 2 : 1;
            else if (m_hw != 0)       m_mode = tm ? 2 : 1;
            else                      m_mode = 0;
            if (m_locked == 0) begin
                m_code   = (f_hi ? 0 : (f_lo ? 4 : 0)) + (f_b ? 2 : 0) + (f_a ? 1 : 0);
                m_stop   = s_stop;
                m_dbg    = s_dbg;
                m_hw     = f_hi;
                m_locked = pg;
            end
            m_sw = sw_n;
        end
    endtask

    task automatic compare();
        int act_t;
        act_t = (m_locked != 0 && (m_hw != 0 || m_sw != 0)) ? 1 : 0;
        chk("R1/R2 locked", locked, m_locked);
        chk("R2/R5 freq_code", code, m_code);
        chk("R5 freq_rsvd", rsvd, (m_code == 7) ? 1 : 0);
        chk("R3 stop_in_en", stop_en, m_stop == 0);
        chk("R3 extra_pair_en", extra_en, m_stop);
        chk("R4 dbg_pair_en", dbg_en, m_dbg);
        chk("R4 gp_pair_en", gp_en, m_dbg == 0);
        chk("R9 test_active", tact, act_t);
        chk("R6/R7/R8/R10 out_mode", mode, m_mode);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        #(5 * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        step(3);
        chk("R1 mode after reset", mode, 0);
        chk("R1 test inactive", tact, 0);
        rst_n = 1'b1;
        // R2: latches open, outputs follow pins; R11 entry before lock ignored
        entry = 1'b1; sel = 1'b1;
        s_stop = 1'b1; s_dbg = 1'b1; f_lo = 1'b1; f_b = 1'b1; step(2);
        chk("R2 tracking dbg", dbg_en, 1);
        s_dbg = 1'b0; f_a = 1'b1; step(2);
        entry = 1'b0; sel = 1'b0; f_b = 1'b0; step(1);
        // lock: stop=1 dbg=0 code 101
        pg = 1'b1; step(1);
        chk("R2 locked", locked, 1);
        chk("R5 code 101", code, 5);
        chk("R11 early entry ignored", tact, 0);
        s_stop = 1'b0; s_dbg = 1'b1; f_lo = 1'b0; f_a = 1'b0; f_hi = 1'b1; step(3);
        chk("R2 hold code", code, 5);
        chk("R3 extra pair kept", extra_en, 1);
        // no test: pins and select bit have no effect
        tm = 1'b1; sel = 1'b1; step(2);
        chk("R10 normal without test", mode, 0);
        // R11: entry while power-good low ignored; R2 latches stay closed
        pg = 1'b0; entry = 1'b1; step(2);
        entry = 1'b0; step(1);
        pg = 1'b1; step(2);
        chk("R11 entry pg low ignored", tact, 0);
        chk("R2 no reopen", code, 5);
        // R7: register entry, pin ignored
        sel = 1'b0; entry = 1'b1; step(1);
        chk("R7 hiz", mode, 1);
        entry = 1'b0; tm = 1'b0; step(1); tm = 1'b1; step(1);
        chk("R7 pin ignored", mode, 1);
        sel = 1'b1; step(1);
        chk("R7 refdiv", mode, 2);
        // R9 / R10: sticky through power-good drop
        pg = 1'b0; step(2);
        chk("R10 pg low normal", mode, 0);
        chk("R9 sticky", tact, 1);
        pg = 1'b1; step(2);
        chk("R9 resumes", mode, 2);
        // power cycle, then hardware test entry
        rst_n = 1'b0; pg = 1'b0; sel = 1'b0; tm = 1'b0; step(2);
        chk("R9 cleared by reset", tact, 0);
        rst_n = 1'b1; f_hi = 1'b1; f_lo = 1'b1; f_b = 1'b1; f_a = 1'b1; step(1);
        pg = 1'b1; step(1);
        chk("R5 msb forced 0", code, 3);
        chk("R6 test active", tact, 1);
        chk("R6 mode lags lock", mode, 0);
        step(1);
        chk("R6 hiz", mode, 1);
        tm = 1'b1; step(1);
        chk("R6 refdiv", mode, 2);
        tm = 1'b0; step(1);
        // R8: both sources, sel decides
        entry = 1'b1; sel = 1'b1; step(1);
        entry = 1'b0; step(1);
        chk("R8 sel over pin", mode, 2);
        sel = 1'b0; tm = 1'b1; step(1);
        chk("R8 sel hiz", mode, 1);
        // reserved code
        rst_n = 1'b0; pg = 1'b0; step(2);
        rst_n = 1'b1; f_hi = 1'b0; step(1);
        pg = 1'b1; step(2);
        chk("R5 reserved", rsvd, 1);
        chk("R10 normal no test", mode, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule